// File: doc/BRIEF.md
# Device Identifier Lock Checker

This block runs a single identity check after the device has finished configuring. It reads the factory-programmed per-chip identifier out of an on-chip serial read/shift port, rebuilds the full 64-bit value and compares it with an expected identifier fixed at build time by a parameter. Until the check is over, and forever after if it fails, it holds the downstream user logic in reset. Only a match releases that reset. The block runs from an internal oscillator clock, so stopping an external clock cannot stall or skip the check.

The serial port holds only the upper 57 identifier bits. The block therefore pushes the 7 missing low bits, taken from the expected value, into the port's serial input while it shifts. After 57 shifts those bits come back out, so a full 64-bit stream leaves the port and is compared bit by bit. A side effect is that the low 7 bits of the device's own identifier cannot change the verdict. What the check does prove is that the port's shift chain has the length and order the block assumes.

The check starts when the end-of-startup input goes high. That input passes through a synchronizer first. The check runs once per power-on reset, and its verdict is latched.

Top module: `idlock_top`

## Requirements
- R1: While reset is applied and directly after it, `port_load_o`, `port_shift_o`, `port_din_o`, `chk_done_o` and `chk_pass_o` are 0 and `user_rst_o` is 1.
- R2: No port activity occurs while `startup_done_i` stays low, however long that lasts.
- R3: `port_load_o` goes high exactly SYNC_STAGES+1 rising edges after `startup_done_i` rises, and stays high for one cycle. `port_shift_o` is then high for exactly 64 consecutive cycles.
- R4: The serial output is taken most-significant bit first. On the k-th shift cycle (k = 0..63), the bit read is compared with expected bit 63-k.
- R5: During the first 7 shift cycles, `port_din_o` carries expected bits 6, 5, …, 0 in that order. It is 0 at all other times. As a result, a device whose identifier differs from the expected value only in bits 6..0 passes.
- R6: `chk_done_o` rises exactly SYNC_STAGES+66 edges after `startup_done_i` rises, on the same edge where shifting ends. It then stays high.
- R7: `user_rst_o` stays 1 until `chk_done_o` is 1. It falls to 0 on that edge only if all 64 compared bits matched, and otherwise stays 1.
- R8: After the check, further changes on `startup_done_i` start no new load or shift. `chk_pass_o` and `user_rst_o` hold their values until the next reset.
- R9: A difference in any single identifier bit from 63 down to 7 gives `chk_pass_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal oscillator clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| startup_done_i | input | 1 | End-of-startup indication, asynchronous |
| port_load_o | output | 1 | Capture the identifier into the port's shift register |
| port_shift_o | output | 1 | Shift the port's register by one bit |
| port_dout_i | input | 1 | Port serial output, current MSB of its register |
| port_din_o | output | 1 | Bit fed into the port's serial input |
| chk_done_o | output | 1 | Check finished (sticky) |
| chk_pass_o | output | 1 | Latched verdict, 1 = identifier matched |
| user_rst_o | output | 1 | Active-high reset for downstream logic |

## Verification
All timing is counted from the rising edge that first follows the rise of `startup_done_i`. The load pulse is due after 3 edges, the first shift cycle after 4, and done, pass and the reset release after 68 (with two synchronizer stages). The bench raises `startup_done_i` on a falling clock edge and counts falling edges from there. At each falling edge it has seen exactly as many rising edges as it has counted, so each output is sampled in the exact cycle it is due, and also one cycle before where that matters. A behavioural 57-bit port model records the fed-back bits and the number of loads and shifts. The bench checks those records after the verdict and again after `startup_done_i` is toggled later.

// File: rtl/idlock_pkg.sv
package idlock_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOAD  = 2'd1,
    ST_SHIFT = 2'd2,
    ST_DONE  = 2'd3
  } idlock_state_e;
endpackage

// File: rtl/idlock_sync.sv
// Multi-flop synchronizer with asynchronous active-low clear.
module idlock_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;
  logic [STAGES-1:0] pipe_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb pipe_d = d_i;
    end else begin : g_many
      always_comb pipe_d = {pipe_q[STAGES-2:0], d_i};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '0;
    else         pipe_q <= pipe_d;
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/idlock_seq.sv
// One-shot read sequencer: idle -> load (1 cycle) -> shift (ID_W cycles) -> done.
module idlock_seq
  import idlock_pkg::*;
#(
  parameter int ID_W  = 64,
  parameter int CNT_W = $clog2(ID_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic             load_o,
  output logic             shift_o,
  output logic [CNT_W-1:0] idx_o,
  output logic             last_o
);
  idlock_state_e    state_q, state_d;
  logic [CNT_W-1:0] idx_q, idx_d;
  logic             idx_en;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    idx_en  = 1'b0;
    unique case (state_q)
      ST_IDLE:  if (start_i) state_d = ST_LOAD;
      ST_LOAD: begin
        state_d = ST_SHIFT;
        idx_d   = '0;
        idx_en  = 1'b1;
      end
      ST_SHIFT: begin
        if (idx_q == CNT_W'(ID_W-1)) begin
          state_d = ST_DONE;
        end else begin
          idx_d  = idx_q + 1'b1;
          idx_en = 1'b1;
        end
      end
      ST_DONE:  state_d = ST_DONE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     idx_q <= '0;
    else if (idx_en) idx_q <= idx_d;
  end

  assign load_o  = (state_q == ST_LOAD);
  assign shift_o = (state_q == ST_SHIFT);
  assign idx_o   = idx_q;
  assign last_o  = shift_o && (idx_q == CNT_W'(ID_W-1));
endmodule

// File: rtl/idlock_cmp.sv
// Bit-serial comparator and low-bit feeder for the truncated identifier port.
module idlock_cmp #(
  parameter int              ID_W   = 64,
  parameter int              PORT_W = 57,
  parameter logic [ID_W-1:0] EXP_ID = '0,
  parameter int              CNT_W  = $clog2(ID_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             shift_i,
  input  logic [CNT_W-1:0] idx_i,
  input  logic             dout_i,
  output logic             din_o,
  output logic             miss_o
);
  localparam int LOW_W = ID_W - PORT_W;

  logic [CNT_W-1:0] rev_idx;
  logic [CNT_W-1:0] low_idx;
  logic             exp_bit;
  logic             in_low;
  logic             miss_q, miss_d;

  always_comb begin
    rev_idx = CNT_W'(ID_W-1) - idx_i;
    low_idx = CNT_W'(LOW_W-1) - idx_i;
    exp_bit = EXP_ID[rev_idx];
    in_low  = (idx_i < CNT_W'(LOW_W));
    din_o   = shift_i && in_low && EXP_ID[low_idx];
    miss_d  = miss_q | (shift_i & (dout_i ^ exp_bit));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      miss_q <= 1'b0;
    else if (shift_i) miss_q <= miss_d;
  end

  // includes the bit being compared this cycle
  assign miss_o = miss_d;
endmodule

// File: rtl/idlock_top.sv
module idlock_top #(
  parameter int              ID_W        = 64,
  parameter int              PORT_W      = 57,
  parameter int              SYNC_STAGES = 2,
  parameter logic [ID_W-1:0] EXP_ID      = 64'hA5C3_1F07_9B2E_6D48
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic startup_done_i,
  output logic port_load_o,
  output logic port_shift_o,
  input  logic port_dout_i,
  output logic port_din_o,
  output logic chk_done_o,
  output logic chk_pass_o,
  output logic user_rst_o
);
  localparam int CNT_W = $clog2(ID_W);

  logic             rst_n_int;
  logic             start_sync;
  logic             shift_w;
  logic             last_w;
  logic             miss_w;
  logic [CNT_W-1:0] idx_w;
  logic             done_q, done_d;
  logic             pass_q, pass_d;
  logic             urst_q, urst_d;

  // reset: asserted asynchronously, released through the synchronizer
  idlock_sync #(.STAGES(2)) u_rst_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (1'b1),
    .q_o   (rst_n_int)
  );

  idlock_sync #(.STAGES(SYNC_STAGES)) u_start_sync (
    .clk_i (clk_i),
    .rst_ni(rst_n_int),
    .d_i   (startup_done_i),
    .q_o   (start_sync)
  );

  idlock_seq #(.ID_W(ID_W), .CNT_W(CNT_W)) u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_n_int),
    .start_i(start_sync),
    .load_o (port_load_o),
    .shift_o(shift_w),
    .idx_o  (idx_w),
    .last_o (last_w)
  );

  idlock_cmp #(.ID_W(ID_W), .PORT_W(PORT_W), .EXP_ID(EXP_ID), .CNT_W(CNT_W)) u_cmp (
    .clk_i  (clk_i),
    .rst_ni (rst_n_int),
    .shift_i(shift_w),
    .idx_i  (idx_w),
    .dout_i (port_dout_i),
    .din_o  (port_din_o),
    .miss_o (miss_w)
  );

  always_comb begin
    done_d = 1'b1;
    pass_d = ~miss_w;
    urst_d = miss_w;
  end

  // verdict latched once, on the last shift cycle
  always_ff @(posedge clk_i or negedge rst_n_int) begin
    if (!rst_n_int) begin
      done_q <= 1'b0;
      pass_q <= 1'b0;
      urst_q <= 1'b1;
    end else if (last_w) begin
      done_q <= done_d;
      pass_q <= pass_d;
      urst_q <= urst_d;
    end
  end

  assign port_shift_o = shift_w;
  assign chk_done_o   = done_q;
  assign chk_pass_o   = pass_q;
  assign user_rst_o   = urst_q;
endmodule

// File: rtl/idlock_chk.sv
module idlock_chk #(
  parameter int ID_W = 64
) (
  input logic clk_i,
  input logic rst_ni,
  input logic startup_done_i,
  input logic port_load_o,
  input logic port_shift_o,
  input logic chk_done_o,
  input logic chk_pass_o,
  input logic user_rst_o
);
  logic        seen_q;
  logic [15:0] nshift_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q   <= 1'b0;
      nshift_q <= '0;
    end else begin
      if (startup_done_i) seen_q <= 1'b1;
      if (port_shift_o)   nshift_q <= nshift_q + 1'b1;
    end
  end

  p_no_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (port_load_o || port_shift_o) |-> seen_q);
  p_load_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    port_load_o |=> (!port_load_o && port_shift_o));
  p_shift_len_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(chk_done_o) |-> (nshift_q == 16'(ID_W)));
  p_shift_end_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(port_shift_o) |-> chk_done_o);
  p_done_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_done_o |=> chk_done_o);
  p_fail_safe_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !chk_done_o |-> user_rst_o);
  p_pass_done_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_pass_o |-> chk_done_o);
  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_done_o |=> ($stable(chk_pass_o) && $stable(user_rst_o)
                    && !port_load_o && !port_shift_o));
endmodule

bind idlock_top idlock_chk #(.ID_W(ID_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .startup_done_i(startup_done_i),
  .port_load_o   (port_load_o),
  .port_shift_o  (port_shift_o),
  .chk_done_o    (chk_done_o),
  .chk_pass_o    (chk_pass_o),
  .user_rst_o    (user_rst_o)
);

// File: tb/sim_idlock_top.sv
`timescale 1ns/1ps
module sim_idlock_top;
  localparam logic [63:0] EXP  = 64'hA5C3_1F07_9B2E_6D48;
  localparam int          SYNC = 2;
  localparam int LAT_LOAD = SYNC + 1;
  localparam int LAT_DONE = SYNC + 66;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic startup = 1'b0;
  logic load, shift, dout, din, done, pass, urst;
  logic [63:0] dev_id = '0;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  idlock_top #(.SYNC_STAGES(SYNC), .EXP_ID(EXP)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .startup_done_i(startup),
    .port_load_o(load), .port_shift_o(shift), .port_dout_i(dout),
    .port_din_o(din), .chk_done_o(done), .chk_pass_o(pass), .user_rst_o(urst)
  );

  // behavioural 57-bit identifier port
  logic [56:0] sr;
  int          n_load, n_shift;
  logic [6:0]  din_seen;

  assign dout = sr[56];

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      sr <= '0; n_load <= 0; n_shift <= 0; din_seen <= '0;
    end else if (load) begin
      sr <= dev_id[63:7];
      n_load <= n_load + 1;
    end else if (shift) begin
      sr <= {sr[55:0], din};
      if (n_shift < 7) din_seen[6-n_shift] <= din;
      n_shift <= n_shift + 1;
    end
  end

  function automatic bit exp_pass(input logic [63:0] id);
    return id[63:7] == EXP[63:7];
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, expv);
    end
  endtask

  task automatic run_one(input logic [63:0] id, input int pre_idle);
    bit p;
    p = exp_pass(id);
    rst_ni  = 1'b0;
    startup = 1'b0;
    dev_id  = id;
    repeat (3) @(negedge clk);
    check(!load && !shift && !din && !done && !pass && urst, "R1", "reset outputs",
          {58'd0, load, shift, din, done, pass, urst}, 64'h1);
    rst_ni = 1'b1;
    repeat (pre_idle) @(negedge clk);
    check(n_load == 0 && n_shift == 0 && !load && !shift && urst, "R2", "idle before startup",
          64'(n_load + n_shift), 64'd0);
    check(!done && urst, "R1", "after reset release", {62'd0, done, urst}, 64'h1);
    startup = 1'b1;
    for (int e = 1; e <= LAT_DONE; e++) begin
      @(negedge clk);
      if (e == LAT_LOAD - 1) check(!load, "R3", "load early", 64'(load), 64'd0);
      if (e == LAT_LOAD)     check(load && !shift, "R3", "load pulse", {62'd0, load, shift}, 64'h2);
      if (e == LAT_LOAD + 1) check(!load && shift, "R3", "shift start", {62'd0, load, shift}, 64'h1);
      if (e == LAT_DONE - 1) check(!done && urst && shift, "R6", "done early",
                                   {61'd0, done, urst, shift}, 64'h3);
    end
    check(done && !shift, "R6", "done on time", {62'd0, done, shift}, 64'h2);
    check(pass == p, "R9", "verdict", 64'(pass), 64'(p));
    check(urst == !p, "R7", "user reset", 64'(urst), 64'(!p));
    check(n_shift == 64 && n_load == 1, "R3", "shift count", 64'(n_shift), 64'd64);
    check(din_seen == EXP[6:0], "R5", "fed low bits", 64'(din_seen), 64'(EXP[6:0]));
    startup = 1'b0;
    repeat (10) @(negedge clk);
    startup = 1'b1;
    repeat (40) @(negedge clk);
    check(n_load == 1 && n_shift == 64 && done && pass == p && urst == !p && !din,
          "R8", "no re-run", 64'(n_load * 1000 + n_shift), 64'd1064);
  endtask

  initial begin
    logic [63:0] id;
    void'($urandom(32'd20240517));
    // directed
    run_one(EXP, 4);                                   // R4 full match
    run_one(EXP ^ 64'h0000_0000_0000_0048, 5);         // R5 low bits differ -> pass
    run_one(EXP ^ 64'h0000_0000_0000_0080, 4);         // R9 bit 7
    run_one(EXP ^ 64'h8000_0000_0000_0000, 6);         // R4 MSB
    run_one(EXP, 150);                                 // R2 long idle
    // random single-bit flips in bits 63..7
    for (int i = 0; i < 6; i++) begin
      int b;
      b = 7 + int'($urandom_range(56));
      run_one(EXP ^ (64'd1 << b), 4 + int'($urandom_range(20)));
    end
    // random identifiers, some with only low bits random
    for (int i = 0; i < 6; i++) begin
      id = {$urandom, $urandom};
      if (i % 2 == 0) id = {EXP[63:7], id[6:0]};
      run_one(id, 4 + int'($urandom_range(20)));
    end
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog R6 act=%h exp=%h", 64'd0, 64'd1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule